// File: doc/BRIEF.md
# Timed Settings Command Scheduler

This block sits beside a streamed sample path. It holds the frequency word and the IQ scale word that a downstream mixer and scaler use. Software writes these words through a settings bus. A write that carries no timestamp changes the register on the next clock. A write that carries a timestamp is placed in a small in-order queue. It is applied on the first processed sample whose time is later than the stamped time, and that sample may fall in the middle of a packet.

The block observes each accepted sample beat together with its sideband. It derives each sample's time from the packet header timestamp plus the sample's position in the packet. Packets that carry no timestamp continue the count from the previous packet. The words on the outputs are valid for the sample presented in the same cycle. A timed frequency change also raises a phase restart pulse on the sample it first applies to, so the accumulator restarts from zero there.

Top module: `timed_cfg_sched`

## Requirements
- R1: After reset, freq_word is 0, scale_word is 0x08000 (unity with 15 fractional bits), q_full is 0 and phase_zero is 0.
- R2: A settings write with cfg_timed low and address 132 (frequency) or 133 (scale) is visible on freq_word or scale_word in the cycle after the strobe, with no sample needed.
- R3: A timed write stamped T is not visible before a sample is processed. Samples with time up to and including T see the old word. The sample with time T+1 and all later samples see the new word, in the same cycle as that sample's beat.
- R4: phase_zero pulses for exactly the sample on which a timed frequency write first applies. It stays low when a timed scale write applies and when no sample beat is present.
- R5: The first beat of a packet takes its time from sideband bits 63:0 when sideband bit 125 is set. Every other beat, including the first beat of a packet with bit 125 clear, takes the previous beat's time plus one. smp_last marks the final beat of a packet.
- R6: Timed commands apply strictly in arrival order, at most one per sample. A head command whose time is already earlier than the current sample applies on that sample.
- R7: The queue holds 8 commands. q_full is high while 8 are held, and a timed write that arrives while the queue is full is discarded.
- R8: A pulse on clear removes all queued commands, and none of them is applied afterwards.
- R9: Writes to any address other than 132 or 133, timed or not, change no output and are not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Flush the timed-command queue |
| cfg_stb | input | 1 | Settings write strobe, one cycle |
| cfg_addr | input | 8 | Settings register address |
| cfg_data | input | 32 | Settings write data |
| cfg_time | input | 64 | Sample time stamped on the write |
| cfg_timed | input | 1 | Write carries a timestamp |
| smp_valid | input | 1 | A sample beat is accepted this cycle |
| smp_last | input | 1 | Beat is the last of its packet |
| smp_user | input | 128 | Per-sample sideband (timestamp flag, timestamp) |
| q_full | output | 1 | Timed-command queue is full |
| freq_word | output | 32 | Phase increment in force for the current sample |
| scale_word | output | 18 | IQ scale in force for the current sample |
| phase_zero | output | 1 | Restart the phase accumulator on this sample |

## Verification
The hardest case is a command due exactly at a packet boundary. The stamped time is the last sample of one packet, and the next packet carries no header timestamp, so its first sample's time exists only as a continued count. The bench reaches this by stamping a command with the final sample's time and following that packet with an untimed packet. It then checks that the switch and the phase pulse land on the untimed packet's first beat. A second hard case is several commands due at once. The bench stamps two commands with a time already long past and checks that they resolve over successive samples in arrival order.

// File: rtl/timed_cfg_sched.sv
module timed_cfg_sched #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int TIME_W      = 64,
  parameter int USER_W      = 128,
  parameter int TS_FLAG_BIT = 125,
  parameter int FREQ_ADDR   = 132,
  parameter int SCALE_ADDR  = 133,
  parameter int SCALE_W     = 18,
  parameter int SCALE_FRAC  = 15,
  parameter int DEPTH       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              cfg_stb,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [TIME_W-1:0] cfg_time,
  input  logic              cfg_timed,
  input  logic              smp_valid,
  input  logic              smp_last,
  input  logic [USER_W-1:0] smp_user,
  output logic              q_full,
  output logic [DATA_W-1:0] freq_word,
  output logic [SCALE_W-1:0] scale_word,
  output logic              phase_zero
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [SCALE_W-1:0] SCALE_ONE = SCALE_W'(1) << SCALE_FRAC;

  logic [PW:0]         wr_ptr, rd_ptr;
  logic [DATA_W-1:0]   q_data [DEPTH];
  logic [TIME_W-1:0]   q_time [DEPTH];
  logic                q_isf  [DEPTH];
  logic [DATA_W-1:0]   freq_q;
  logic [SCALE_W-1:0]  scale_q;
  logic [TIME_W-1:0]   next_t;
  logic                sop;

  wire [PW:0]       occ   = wr_ptr - rd_ptr;
  wire [PW-1:0]     ri    = rd_ptr[PW-1:0];
  wire              hit_f = cfg_addr == ADDR_W'(FREQ_ADDR);
  wire              hit_s = cfg_addr == ADDR_W'(SCALE_ADDR);
  wire              imm   = cfg_stb && !cfg_timed;
  wire              push  = cfg_stb && cfg_timed && (hit_f || hit_s) && !q_full && !clear;
  wire [TIME_W-1:0] t_now = (sop && smp_user[TS_FLAG_BIT]) ? smp_user[TIME_W-1:0] : next_t;
  wire              due   = (occ != '0) && (q_time[ri] < t_now);
  wire              apply = smp_valid && due;
  wire              unused_user_bits = ^{smp_user[USER_W-1:TS_FLAG_BIT+1],
                                         smp_user[TS_FLAG_BIT-1:TIME_W]};

  assign q_full     = occ == (PW+1)'(DEPTH);
  assign phase_zero = apply && q_isf[ri];
  assign freq_word  = phase_zero ? q_data[ri] : freq_q;
  assign scale_word = (apply && !q_isf[ri]) ? q_data[ri][SCALE_W-1:0] : scale_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clear) begin
      rd_ptr <= wr_ptr;
    end else begin
      if (push)  wr_ptr <= wr_ptr + 1'b1;
      if (apply) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_data[wr_ptr[PW-1:0]] <= cfg_data;
      q_time[wr_ptr[PW-1:0]] <= cfg_time;
      q_isf[wr_ptr[PW-1:0]]  <= hit_f;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_q  <= '0;
      scale_q <= SCALE_ONE;
    end else begin
      if (imm && hit_f)       freq_q <= cfg_data;
      else if (phase_zero)    freq_q <= q_data[ri];
      if (imm && hit_s)       scale_q <= cfg_data[SCALE_W-1:0];
      else if (apply && !q_isf[ri]) scale_q <= q_data[ri][SCALE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_t <= '0;
      sop    <= 1'b1;
    end else if (smp_valid) begin
      next_t <= t_now + 1'b1;
      sop    <= smp_last;
    end
  end
endmodule

module timed_cfg_sched_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int FREQ_ADDR = 132,
  parameter int DEPTH     = 8,
  parameter int PW        = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              clear,
  input logic              cfg_stb,
  input logic              cfg_timed,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_data,
  input logic              smp_valid,
  input logic [DATA_W-1:0] freq_word,
  input logic              phase_zero,
  input logic              q_full,
  input logic [PW:0]       wr_ptr,
  input logic [PW:0]       rd_ptr
);
  a_r4_pulse_needs_sample: assert property (@(posedge clk) disable iff (rst)
    phase_zero |-> smp_valid);

  a_r2_untimed_freq: assert property (@(posedge clk) disable iff (rst)
    (cfg_stb && !cfg_timed && cfg_addr == ADDR_W'(FREQ_ADDR))
      |=> (phase_zero || freq_word == $past(cfg_data)));

  a_r3_hold_without_sample: assert property (@(posedge clk) disable iff (rst)
    !cfg_stb |=> (smp_valid || freq_word == $past(freq_word)));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr - rd_ptr) <= (PW+1)'(DEPTH));

  a_r7_full_blocks_push: assert property (@(posedge clk) disable iff (rst)
    (q_full && !smp_valid && !clear) |=> $stable(wr_ptr));

  a_r8_clear_flush: assert property (@(posedge clk) disable iff (rst)
    clear |=> (!q_full && wr_ptr == rd_ptr));
endmodule

bind timed_cfg_sched timed_cfg_sched_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FREQ_ADDR(FREQ_ADDR), .DEPTH(DEPTH), .PW(PW)
) u_chk (
  .clk(clk), .rst(rst), .clear(clear), .cfg_stb(cfg_stb), .cfg_timed(cfg_timed),
  .cfg_addr(cfg_addr), .cfg_data(cfg_data), .smp_valid(smp_valid),
  .freq_word(freq_word), .phase_zero(phase_zero), .q_full(q_full),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/timed_cfg_sched_tb.sv
module timed_cfg_sched_tb;
  localparam int HALF = 5; // 10 ns period, 100 MHz

  logic         clk = 0;
  logic         rst = 1;
  logic         clear = 0;
  logic         cfg_stb = 0;
  logic [7:0]   cfg_addr = 0;
  logic [31:0]  cfg_data = 0;
  logic [63:0]  cfg_time = 0;
  logic         cfg_timed = 0;
  logic         smp_valid = 0;
  logic         smp_last = 0;
  logic [127:0] smp_user = 0;
  logic         q_full;
  logic [31:0]  freq_word;
  logic [17:0]  scale_word;
  logic         phase_zero;

  int checks = 0;
  int failures = 0;
  logic [31:0] ob_f;
  logic [17:0] ob_s;
  logic        ob_pz;

  timed_cfg_sched u_dut (
    .clk(clk), .rst(rst), .clear(clear), .cfg_stb(cfg_stb), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_time(cfg_time), .cfg_timed(cfg_timed),
    .smp_valid(smp_valid), .smp_last(smp_last), .smp_user(smp_user),
    .q_full(q_full), .freq_word(freq_word), .scale_word(scale_word),
    .phase_zero(phase_zero)
  );

  always #HALF clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic timed, input logic [63:0] t);
    @(negedge clk);
    cfg_stb = 1; cfg_addr = a; cfg_data = d; cfg_timed = timed; cfg_time = t;
    @(posedge clk); #1;
    cfg_stb = 0;
  endtask

  task automatic beat(input logic has_ts, input logic [63:0] ts, input logic last);
    @(negedge clk);
    smp_valid = 1; smp_last = last;
    smp_user = '0; smp_user[125] = has_ts; smp_user[124] = last; smp_user[63:0] = ts;
    #1;
    ob_f = freq_word; ob_s = scale_word; ob_pz = phase_zero;
    @(posedge clk); #1;
    smp_valid = 0;
  endtask

  task automatic t_reset();
    chk(freq_word == 0, "R1 freq", freq_word, 0);
    chk(scale_word == 18'h08000, "R1 scale", scale_word, 18'h08000);
    chk(q_full == 0, "R1 full", q_full, 0);
    chk(phase_zero == 0, "R1 pz", phase_zero, 0);
  endtask

  task automatic t_untimed();
    wr(8'd132, 32'h1111, 0, 0);
    chk(freq_word == 32'h1111, "R2 freq", freq_word, 32'h1111);
    wr(8'd133, 32'h4000, 0, 0);
    chk(scale_word == 18'h4000, "R2 scale", scale_word, 18'h4000);
    wr(8'd5, 32'hdead, 0, 0);
    chk(freq_word == 32'h1111 && scale_word == 18'h4000, "R9 untimed other addr", freq_word, 32'h1111);
    wr(8'd5, 32'hbeef, 1, 0);
    beat(1, 64'd50, 1);
    chk(ob_f == 32'h1111 && ob_s == 18'h4000 && !ob_pz, "R9 timed other addr", ob_f, 32'h1111);
  endtask

  task automatic t_mid_packet();
    wr(8'd132, 32'hA0, 1, 64'd103);
    repeat (3) @(posedge clk);
    #1 chk(freq_word == 32'h1111, "R3 deferred", freq_word, 32'h1111);
    for (int i = 0; i < 8; i++) begin
      beat(i == 0, 64'd100, i == 7);
      chk(ob_f == (i <= 3 ? 32'h1111 : 32'hA0), "R3 mid packet switch", ob_f, i <= 3 ? 32'h1111 : 32'hA0);
      chk(ob_pz == (i == 4), "R4 pulse on switch sample", ob_pz, i == 4);
    end
  endtask

  task automatic t_packet_end();
    wr(8'd132, 32'hB0, 1, 64'd203);
    for (int i = 0; i < 4; i++) begin
      beat(i == 0, 64'd200, i == 3);
      chk(ob_f == 32'hA0 && !ob_pz, "R3 before last sample", ob_f, 32'hA0);
    end
    beat(0, 64'd0, 0);
    chk(ob_f == 32'hB0, "R5 continued count", ob_f, 32'hB0);
    chk(ob_pz == 1, "R4 pulse at boundary", ob_pz, 1);
    beat(0, 64'd0, 1);
    chk(ob_f == 32'hB0 && !ob_pz, "R4 single pulse", ob_pz, 0);
  endtask

  task automatic t_before_packet();
    wr(8'd133, 32'h2000, 1, 64'd299);
    beat(1, 64'd300, 0);
    chk(ob_s == 18'h2000, "R3 first sample scale", ob_s, 18'h2000);
    chk(ob_pz == 0, "R4 no pulse for scale", ob_pz, 0);
    beat(0, 64'd0, 1);
    chk(ob_s == 18'h2000, "R3 scale held", ob_s, 18'h2000);
  endtask

  task automatic t_order();
    wr(8'd132, 32'hC0, 1, 64'd5);
    wr(8'd133, 32'h1000, 1, 64'd5);
    beat(1, 64'd400, 0);
    chk(ob_f == 32'hC0 && ob_s == 18'h2000 && ob_pz, "R6 first in order", ob_f, 32'hC0);
    beat(0, 64'd0, 0);
    chk(ob_s == 18'h1000 && !ob_pz, "R6 second in order", ob_s, 18'h1000);
    beat(0, 64'd0, 1);
    chk(ob_f == 32'hC0 && ob_s == 18'h1000, "R6 held", ob_f, 32'hC0);
  endtask

  task automatic t_full();
    for (int k = 1; k <= 8; k++) wr(8'd132, k, 1, 64'd1000);
    chk(q_full == 1, "R7 full at 8", q_full, 1);
    wr(8'd132, 32'd99, 1, 64'd1000);
    for (int k = 0; k < 9; k++) begin
      beat(k == 0, 64'd2000, k == 8);
      chk(ob_f == (k < 8 ? k + 1 : 8), "R7 drained in order", ob_f, k < 8 ? k + 1 : 8);
      chk(ob_pz == (k < 8), "R7 dropped write", ob_pz, k < 8);
      if (k == 0) chk(q_full == 0, "R7 not full after pop", q_full, 0);
    end
  endtask

  task automatic t_clear();
    wr(8'd132, 32'hE0, 1, 64'd0);
    repeat (2) @(posedge clk);
    #1 chk(freq_word == 32'd8, "R3 past due waits for sample", freq_word, 8);
    for (int k = 0; k < 7; k++) wr(8'd133, 32'h3000 + k, 1, 64'd0);
    chk(q_full == 1, "R7 full again", q_full, 1);
    @(negedge clk); clear = 1;
    @(posedge clk); #1 clear = 0;
    chk(q_full == 0, "R8 clear empties", q_full, 0);
    for (int k = 0; k < 3; k++) begin
      beat(k == 0, 64'd5000, k == 2);
      chk(ob_f == 32'd8 && ob_s == 18'h1000 && !ob_pz, "R8 nothing applied", ob_f, 8);
    end
  endtask

  initial begin
    #(HALF * 200000);
    failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    #1;
    t_reset();
    t_untimed();
    t_mid_packet();
    t_packet_end();
    t_before_packet();
    t_order();
    t_full();
    t_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule